// File: doc/BRIEF.md
# DMA Channel Register File

This block is the register front end of a two-channel scatter-gather DMA engine. Software reaches it over a plain 32-bit memory-mapped port. The port carries an address, a write strobe with write data, and a read strobe. Read data returns one cycle after the strobe. Each channel owns a 48-byte window holding four registers: a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. The channel is picked from the address, and windows repeat across the address space.

The descriptor engine sits next to this block and talks to it through plain pins. It supplies each channel's live completion counter and delay-timer count. It raises interrupt flags and the idle condition with one-cycle set strobes. In return it receives a one-cycle start pulse whenever software writes a tail pointer. Each channel drives one level interrupt from its flags gated by the enable bits in its control word.

There is no streaming data path here, so there is no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented.

Top module: `dmach_regfile`

## Requirements
- R1: After synchronous reset, for each channel: a control read returns 0x0001_0000, status bits 15:0 read 0x0001, and both pointers read 0. Both irq outputs and both start outputs are low.
- R2: The channel index is (address / 48) mod 2 and the word index is (address mod 48) >> 2. Word 0 is control, 1 is status, 2 is current descriptor and 4 is tail descriptor. Any other word reads 0, and writes to it change nothing.
- R3: bus_rdata holds the value selected by a read strobe in the cycle after the strobe, and is 0 in the cycle after any cycle without a read strobe.
- R4: A control write with bit 2 clear and no reset pending stores the write data with bit 1 forced to 1.
- R5: A control write with bit 2 set, or while a soft reset is pending, sets control to threshold 1 (bits 23:16 = 1) with bits 2 and 1 set, and sets status bits 15:0 to 0x0001. The pending bit 2 survives later control writes and is cleared by the next control read, which already returns bit 2 as 0 (0x0001_0002 after a reset).
- R6: A control write with bit 0 = 1 and no reset pending clears status bit 0 (halted) and bit 1 (idle).
- R7: Status bits 14:12 are interrupt flags. flag_set bits {3c+2..3c} set channel c's flags, and writing 1 to a flag clears it. A set strobe wins over a clear in the same cycle. Status writes do not touch any other status bit.
- R8: A status read returns {delay timer[7:0], completion counter[7:0], status[15:0]}. It uses the counter inputs of the addressed channel sampled in the cycle of the read strobe. The inputs carry channel 1 in bits 15:8 and channel 0 in bits 7:0.
- R9: A tail write stores the pointer and clears the idle bit. It drives start[c] of that channel alone high for exactly the following cycle.
- R10: irq[c] is high exactly when any of status bits 14:12 of channel c is set together with the same bit of its control register.
- R11: idle_set[c] sets status bit 1 of channel c. A bus write in the same cycle that clears that bit (run or tail write) takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| coal_cnt | input | 16 | Live completion counters, 8 bits per channel |
| dly_tmr | input | 16 | Live delay-timer counts, 8 bits per channel |
| flag_set | input | 6 | Interrupt flag set strobes, 3 per channel |
| idle_set | input | 2 | Idle set strobe per channel |
| start | output | 2 | One-cycle start pulse per channel after a tail write |
| irq | output | 2 | Level interrupt per channel |

## Verification
The bench builds the block with ADDR_W = 8 and a 48-byte window. With these values both channel windows fit in the space, and addresses 96 and above alias back onto channel 0. The same space also holds the undecoded words inside a window (0x0C, 0x2C), the window aliasing, and the channel-1 decode. A behavioural model follows every clock and predicts rdata, start and irq. Directed sequences exercise soft-reset persistence, the clear-on-read of the reset bit, set-versus-clear races on the flags, and idle races against tail writes.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int CH_NUM = 2;
  localparam int CNT_W  = 8;
  localparam int FLG_N  = 3;

  localparam logic [3:0] W_CTRL = 4'd0;
  localparam logic [3:0] W_STAT = 4'd1;
  localparam logic [3:0] W_CUR  = 4'd2;
  localparam logic [3:0] W_TAIL = 4'd4;

  localparam logic [31:0] CTRL_INIT   = 32'h0001_0000;
  localparam logic [31:0] CTRL_SRESET = 32'h0001_0006;
  localparam logic [15:0] STAT_INIT   = 16'h0001;

  localparam int B_RUN   = 0;
  localparam int B_TAILM = 1;
  localparam int B_SRST  = 2;
  localparam int B_HALT  = 0;
  localparam int B_IDLE  = 1;
  localparam int B_FLG   = 12;
endpackage

// File: rtl/dmach_addr_dec.sv
module dmach_addr_dec #(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 48
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              chan,
  output logic [3:0]        widx
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

  assign chan = 1'((addr / WIN) & ADDR_W'(1));
  assign widx = 4'((addr % WIN) >> 2);
endmodule

// File: rtl/dmach_chan.sv
module dmach_chan
  import dmach_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       widx,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [CNT_W-1:0] tmr_in,
  input  logic [FLG_N-1:0] flg_set,
  input  logic             idl_set,
  output logic [31:0]      rd_val,
  output logic             start_o,
  output logic             irq_o
);
  logic [31:0] ctrl_q;
  logic [15:0] stat_q;
  logic [31:0] cur_q;
  logic [31:0] tail_q;
  logic        start_q;
  logic        rst_pend;

  assign rst_pend = ctrl_q[B_SRST] | wdata[B_SRST];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_INIT;
      stat_q  <= STAT_INIT;
      cur_q   <= '0;
      tail_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_en && (widx == W_TAIL);
      stat_q[B_FLG +: FLG_N] <= stat_q[B_FLG +: FLG_N] | flg_set;
      if (idl_set) stat_q[B_IDLE] <= 1'b1;
      if (rd_en && widx == W_CTRL) ctrl_q[B_SRST] <= 1'b0;
      if (wr_en) begin
        case (widx)
          W_CTRL: begin
            if (rst_pend) begin
              ctrl_q <= CTRL_SRESET;
              stat_q <= STAT_INIT;
            end else begin
              ctrl_q <= wdata | (32'd1 << B_TAILM);
              if (wdata[B_RUN]) begin
                stat_q[B_HALT] <= 1'b0;
                stat_q[B_IDLE] <= 1'b0;
              end
            end
          end
          W_STAT: stat_q[B_FLG +: FLG_N] <=
                    (stat_q[B_FLG +: FLG_N] & ~wdata[B_FLG +: FLG_N]) | flg_set;
          W_CUR:  cur_q <= wdata;
          W_TAIL: begin
            tail_q <= wdata;
            stat_q[B_IDLE] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (widx)
      W_CTRL:  rd_val = ctrl_q & ~(32'd1 << B_SRST);
      W_STAT:  rd_val = {tmr_in, cnt_in, stat_q};
      W_CUR:   rd_val = cur_q;
      W_TAIL:  rd_val = tail_q;
      default: rd_val = '0;
    endcase
  end

  assign start_o = start_q;
  assign irq_o   = |(stat_q[B_FLG +: FLG_N] & ctrl_q[B_FLG +: FLG_N]);
endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile
  import dmach_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 48
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_rd,
  output logic [31:0]               bus_rdata,
  input  logic [CH_NUM*CNT_W-1:0]   coal_cnt,
  input  logic [CH_NUM*CNT_W-1:0]   dly_tmr,
  input  logic [CH_NUM*FLG_N-1:0]   flag_set,
  input  logic [CH_NUM-1:0]         idle_set,
  output logic [CH_NUM-1:0]         start,
  output logic [CH_NUM-1:0]         irq
);
  logic        dec_chan;
  logic [3:0]  dec_widx;
  logic [31:0] ch_val [CH_NUM];
  logic [31:0] rdata_q;

  dmach_addr_dec #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
    .addr (bus_addr),
    .chan (dec_chan),
    .widx (dec_widx)
  );

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    dmach_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_wr && (dec_chan == 1'(c))),
      .rd_en   (bus_rd && (dec_chan == 1'(c))),
      .widx    (dec_widx),
      .wdata   (bus_wdata),
      .cnt_in  (coal_cnt[c*CNT_W +: CNT_W]),
      .tmr_in  (dly_tmr[c*CNT_W +: CNT_W]),
      .flg_set (flag_set[c*FLG_N +: FLG_N]),
      .idl_set (idle_set[c]),
      .rd_val  (ch_val[c]),
      .start_o (start[c]),
      .irq_o   (irq[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bus_rd ? ch_val[dec_chan] : '0;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 48
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic [15:0]       coal_cnt,
  input logic [15:0]       dly_tmr,
  input logic [5:0]        flag_set,
  input logic [1:0]        idle_set,
  input logic [1:0]        start,
  input logic [1:0]        irq
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);
  logic [1:0] tail_hit;

  for (genvar c = 0; c < 2; c++) begin : g_chk
    assign tail_hit[c] = bus_wr && (4'((bus_addr % WIN) >> 2) == 4'd4)
                         && (1'((bus_addr / WIN) & ADDR_W'(1)) == 1'(c));

    // R9
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
      start[c] |-> $past(tail_hit[c]));

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[c]) |-> $past(bus_wr || (|flag_set)));
  end

  // R3
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 32'd0);

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start));

  // R1
  irq_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq == 2'b00 && start == 2'b00));
endmodule

bind dmach_regfile dmach_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (.*);

// File: tb/test_dmach_regfile.sv
module test_dmach_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] coal_cnt = 16'h2211;
  logic [15:0] dly_tmr = 16'h4433;
  logic [5:0]  flag_set = '0;
  logic [1:0]  idle_set = '0;
  logic [1:0]  start;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dmach_regfile i_dmach_regfile (.*);

  // behavioural reference
  logic [31:0] m_ctrl [2];
  logic [15:0] m_stat [2];
  logic [31:0] m_cur  [2];
  logic [31:0] m_tail [2];
  logic [31:0] m_rdata;
  logic [1:0]  m_start;
  int mc, mi;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        m_ctrl[k] = 32'h0001_0000; m_stat[k] = 16'h0001;
        m_cur[k] = 0; m_tail[k] = 0;
      end
      m_rdata = 0; m_start = 0;
    end else begin
      mc = (int'(bus_addr) / 48) % 2;
      mi = (int'(bus_addr) % 48) / 4;
      m_start = 0;
      m_rdata = 0;
      if (bus_rd) begin
        case (mi)
          0: m_rdata = m_ctrl[mc] & ~32'h4;
          1: m_rdata = {dly_tmr[mc*8 +: 8], coal_cnt[mc*8 +: 8], m_stat[mc]};
          2: m_rdata = m_cur[mc];
          4: m_rdata = m_tail[mc];
          default: m_rdata = 0;
        endcase
        if (mi == 0) m_ctrl[mc][2] = 1'b0;
      end
      for (int k = 0; k < 2; k++) begin
        m_stat[k][14:12] = m_stat[k][14:12] | flag_set[k*3 +: 3];
        if (idle_set[k]) m_stat[k][1] = 1'b1;
      end
      if (bus_wr) begin
        case (mi)
          0: if (m_ctrl[mc][2] || bus_wdata[2]) begin
               m_ctrl[mc] = 32'h0001_0006; m_stat[mc] = 16'h0001;
             end else begin
               m_ctrl[mc] = bus_wdata | 32'h2;
               if (bus_wdata[0]) m_stat[mc][1:0] = 2'b00;
             end
          1: m_stat[mc][14:12] = (m_stat[mc][14:12] & ~bus_wdata[14:12])
                                 | flag_set[mc*3 +: 3];
          2: m_cur[mc] = bus_wdata;
          4: begin m_tail[mc] = bus_wdata; m_stat[mc][1] = 1'b0; m_start[mc] = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(bus_rdata === m_rdata, "R3 rdata", bus_rdata, m_rdata);
      chk(start === m_start, "R9 start", 32'(start), 32'(m_start));
      for (int k = 0; k < 2; k++)
        chk(irq[k] === |(m_stat[k][14:12] & m_ctrl[k][14:12]), "R10 irq",
            32'(irq[k]), 32'(|(m_stat[k][14:12] & m_ctrl[k][14:12])));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(irq === 2'b00 && start === 2'b00, "R1 outputs", 32'({irq, start}), 0);
    rd(8'h00, 32'h0001_0000, "R1 ctrl0");
    rd(8'h04, 32'h3311_0001, "R1 R8 stat0");
    rd(8'h38, 32'h0, "R1 cur1");
    rd(8'h34, 32'h4422_0001, "R8 stat1");
    // R2 decode and aliasing
    wr(8'h08, 32'h1234_5678);
    wr(8'h38, 32'hCAFE_0000);
    rd(8'h08, 32'h1234_5678, "R2 cur0");
    rd(8'h38, 32'hCAFE_0000, "R2 cur1");
    rd(8'h68, 32'h1234_5678, "R2 alias");
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R2 undef");
    rd(8'h2C, 32'h0, "R2 undef");
    rd(8'h08, 32'h1234_5678, "R2 undef write ignored");
    @(negedge clk);
    chk(bus_rdata === 0, "R3 idle rdata", bus_rdata, 0);
    // R4 R6
    wr(8'h00, 32'h0000_7001);
    rd(8'h00, 32'h0000_7003, "R4 ctrl");
    rd(8'h04, 32'h3311_0000, "R6 run");
    // R7 R10
    @(negedge clk); flag_set = 6'b000001;
    @(negedge clk); flag_set = 0;
    chk(irq === 2'b01, "R10 irq0", 32'(irq), 1);
    rd(8'h04, 32'h3311_1000, "R7 set");
    wr(8'h04, 32'h0000_1003);
    chk(irq === 2'b00, "R10 cleared", 32'(irq), 0);
    rd(8'h04, 32'h3311_0000, "R7 w1c");
    @(negedge clk); flag_set = 6'b000010; bus_addr = 8'h04; bus_wdata = 32'h2000; bus_wr = 1'b1;
    @(negedge clk); flag_set = 0; bus_wr = 1'b0;
    rd(8'h04, 32'h3311_2000, "R7 set wins");
    wr(8'h04, 32'h0000_2000);
    @(negedge clk); flag_set = 6'b001000;
    @(negedge clk); flag_set = 0;
    chk(irq === 2'b00, "R10 masked", 32'(irq), 0);
    wr(8'h34, 32'h0000_1000);
    // R11 R9
    @(negedge clk); idle_set = 2'b10;
    @(negedge clk); idle_set = 0;
    rd(8'h34, 32'h4422_0003, "R11 idle");
    @(negedge clk); bus_addr = 8'h40; bus_wdata = 32'h0000_1000; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk(start === 2'b10, "R9 pulse", 32'(start), 2);
    @(negedge clk);
    chk(start === 2'b00, "R9 pulse end", 32'(start), 0);
    rd(8'h34, 32'h4422_0001, "R9 idle clear");
    rd(8'h40, 32'h0000_1000, "R9 tail");
    @(negedge clk); idle_set = 2'b10; bus_addr = 8'h40; bus_wdata = 32'h2000; bus_wr = 1'b1;
    @(negedge clk); idle_set = 0; bus_wr = 1'b0;
    rd(8'h34, 32'h4422_0001, "R11 bus wins");
    // R5 soft reset
    wr(8'h00, 32'h0000_7005);
    rd(8'h04, 32'h3311_0001, "R5 halted");
    wr(8'h00, 32'h0000_7001);
    rd(8'h04, 32'h3311_0001, "R5 pending");
    rd(8'h00, 32'h0001_0002, "R5 read clears");
    rd(8'h00, 32'h0001_0002, "R5 after clear");
    wr(8'h00, 32'h0000_0001);
    rd(8'h00, 32'h0000_0003, "R4 after reset");
    rd(8'h04, 32'h3311_0000, "R6 run after reset");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule